// File: doc/BRIEF.md
# Direct-Mapped Write-Back Cache Controller

This block sits between a processor-side port that moves one word per request and a main-memory port that moves one whole block per request. Each byte address splits into a tag, a line index and a block offset. Because every memory block has exactly one line it can occupy, that line is found directly from the index. Each line keeps a valid flag, a dirty flag, a stored tag and a full data block.

A read hit returns the addressed word. A write hit updates the word inside the line and marks the line dirty, with no memory traffic. On a miss the controller stalls the processor port. If the victim line is dirty, it first writes the victim block back to memory. It then fetches the missing block, installs it and repeats the lookup. A write miss therefore allocates the line before the write is merged.

The geometry (address width, index width, offset width, word width) is set by parameters. A 32-bit address with a 13-bit tag, 14-bit index and 5-bit offset is a legal build. The defaults are smaller so that the default elaboration stays compact.

Top module: `dm_wb_cache`

## Requirements
- R1: A byte address splits, from most to least significant bit, into tag, index (INDEX_W bits) and offset (OFFSET_W bits). A block maps to line (block number mod 2^INDEX_W), so addresses that differ only in the tag compete for the same line.
- R2: Reset clears every valid flag, so the first access to any block after reset produces a memory read.
- R3: A hit needs the indexed line to be valid and its tag to equal the address tag. A read hit makes no memory request and raises cpu_resp_valid for one cycle, two clock edges after acceptance.
- R4: A read returns word k of the block, where k = offset bits [OFFSET_W-1:2] and word k occupies block bits [32k+31:32k].
- R5: A write hit changes only the addressed word of the line, issues no memory request, and is returned by a later read of that word.
- R6: A miss on a valid, dirty line first issues a memory write (mem_we=1) of the whole stored block to address {stored tag, index, zero offset}, and only then issues the read of the new block.
- R7: A miss on an invalid or clean line issues only a memory read (mem_we=0), with no write-back.
- R8: Every memory request uses a block-aligned address (low OFFSET_W bits zero). After a refill, further accesses to that block hit.
- R9: A write miss refills the block, merges the write word and marks the line dirty. A later eviction writes back the merged block.
- R10: cpu_ready is high only when idle. It drops in the cycle after acceptance and stays low while a memory request is open.
- R11: mem_req, mem_addr and mem_we hold steady until mem_ack is seen. A write-back acknowledge is followed at once by a refill read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cpu_valid | input | 1 | Processor request present |
| cpu_ready | output | 1 | Controller can accept a request |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Byte address |
| cpu_wdata | input | WORD_W | Write word |
| cpu_resp_valid | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | WORD_W | Read word, valid with the pulse for reads |
| mem_req | output | 1 | Memory block request |
| mem_we | output | 1 | 1 = write-back, 0 = refill read |
| mem_addr | output | ADDR_W | Block-aligned memory address |
| mem_wblock | output | 8<<OFFSET_W | Block written back |
| mem_ack | input | 1 | Memory completes the request (one-cycle pulse) |
| mem_rblock | input | 8<<OFFSET_W | Block returned by a refill |

## Verification
The bench builds the block with a 32-bit address, a 5-bit offset and a 4-bit index, giving 16 lines of 32 bytes. With so few lines, two addresses 512 bytes apart collide on the same line. This makes dirty evictions, clean evictions and write-miss allocation easy to provoke with a handful of accesses. A sweep over all 16 lines then shows that every index maps to its own line.

// File: rtl/dmc_pkg.sv
package dmc_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_COMPARE,
        ST_WRITEBACK,
        ST_REFILL,
        ST_RESPOND
    } dmc_state_e;
endpackage

// File: rtl/dmc_addr_split.sv
module dmc_addr_split #(
    parameter int ADDR_W   = 32,
    parameter int INDEX_W  = 7,
    parameter int OFFSET_W = 5,
    parameter int WORD_W   = 32
) (
    input  logic [ADDR_W-1:0]                        addr,
    output logic [ADDR_W-INDEX_W-OFFSET_W-1:0]       tag,
    output logic [INDEX_W-1:0]                       index,
    output logic [OFFSET_W-$clog2(WORD_W/8)-1:0]     wsel
);
    localparam int BYTE_W = $clog2(WORD_W / 8);

    assign tag   = addr[ADDR_W-1 : INDEX_W+OFFSET_W];
    assign index = addr[INDEX_W+OFFSET_W-1 : OFFSET_W];
    assign wsel  = addr[OFFSET_W-1 : BYTE_W];

    logic unused_byte_bits;
    assign unused_byte_bits = ^addr[BYTE_W-1:0];
endmodule

// File: rtl/dmc_line_store.sv
module dmc_line_store #(
    parameter int INDEX_W = 7,
    parameter int TAG_W   = 20,
    parameter int BLOCK_W = 256
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [INDEX_W-1:0] rd_index,
    output logic               rd_valid,
    output logic               rd_dirty,
    output logic [TAG_W-1:0]   rd_tag,
    output logic [BLOCK_W-1:0] rd_data,
    input  logic               wr_en,
    input  logic [INDEX_W-1:0] wr_index,
    input  logic               wr_valid,
    input  logic               wr_dirty,
    input  logic [TAG_W-1:0]   wr_tag,
    input  logic [BLOCK_W-1:0] wr_data
);
    localparam int LINES = 1 << INDEX_W;

    logic [LINES-1:0]   valid_q;
    logic [LINES-1:0]   dirty_q;
    logic [TAG_W-1:0]   tag_q  [LINES];
    logic [BLOCK_W-1:0] data_q [LINES];

    // line flags are the only state that needs a reset value
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q <= '0;
            dirty_q <= '0;
        end else if (wr_en) begin
            valid_q[wr_index] <= wr_valid;
            dirty_q[wr_index] <= wr_dirty;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_q[wr_index]  <= wr_tag;
            data_q[wr_index] <= wr_data;
        end
    end

    assign rd_valid = valid_q[rd_index];
    assign rd_dirty = dirty_q[rd_index];
    assign rd_tag   = tag_q[rd_index];
    assign rd_data  = data_q[rd_index];
endmodule

// File: rtl/dmc_word_lane.sv
module dmc_word_lane #(
    parameter int BLOCK_W = 256,
    parameter int WORD_W  = 32,
    parameter int WSEL_W  = 3
) (
    input  logic [BLOCK_W-1:0] block,
    input  logic [WSEL_W-1:0]  wsel,
    input  logic [WORD_W-1:0]  wdata,
    output logic [WORD_W-1:0]  rword,
    output logic [BLOCK_W-1:0] merged
);
    localparam int WORDS = BLOCK_W / WORD_W;

    assign rword = block[wsel*WORD_W +: WORD_W];

    for (genvar w = 0; w < WORDS; w++) begin : g_lane
        assign merged[w*WORD_W +: WORD_W] =
            (wsel == WSEL_W'(w)) ? wdata : block[w*WORD_W +: WORD_W];
    end
endmodule

// File: rtl/dm_wb_cache.sv
module dm_wb_cache
    import dmc_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int INDEX_W  = 7,
    parameter int OFFSET_W = 5,
    parameter int WORD_W   = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cpu_valid,
    output logic                    cpu_ready,
    input  logic                    cpu_we,
    input  logic [ADDR_W-1:0]       cpu_addr,
    input  logic [WORD_W-1:0]       cpu_wdata,
    output logic                    cpu_resp_valid,
    output logic [WORD_W-1:0]       cpu_rdata,
    output logic                    mem_req,
    output logic                    mem_we,
    output logic [ADDR_W-1:0]       mem_addr,
    output logic [(8<<OFFSET_W)-1:0] mem_wblock,
    input  logic                    mem_ack,
    input  logic [(8<<OFFSET_W)-1:0] mem_rblock
);
    localparam int TAG_W   = ADDR_W - INDEX_W - OFFSET_W;
    localparam int BLOCK_W = 8 << OFFSET_W;
    localparam int WSEL_W  = OFFSET_W - $clog2(WORD_W / 8);

    typedef struct packed {
        dmc_state_e          state;
        logic                we;
        logic [ADDR_W-1:0]   addr;
        logic [WORD_W-1:0]   wdata;
        logic [WORD_W-1:0]   rdata;
    } ctrl_t;

    ctrl_t ctrl_d, ctrl_q;

    logic [TAG_W-1:0]   req_tag;
    logic [INDEX_W-1:0] req_index;
    logic [WSEL_W-1:0]  req_wsel;

    logic               line_valid, line_dirty;
    logic [TAG_W-1:0]   line_tag;
    logic [BLOCK_W-1:0] line_data;

    logic               lw_en, lw_valid, lw_dirty;
    logic [TAG_W-1:0]   lw_tag;
    logic [BLOCK_W-1:0] lw_data;

    logic [WORD_W-1:0]  sel_word;
    logic [BLOCK_W-1:0] merged_block;
    logic               hit;

    dmc_addr_split #(
        .ADDR_W(ADDR_W), .INDEX_W(INDEX_W), .OFFSET_W(OFFSET_W), .WORD_W(WORD_W)
    ) u_split (
        .addr  (ctrl_q.addr),
        .tag   (req_tag),
        .index (req_index),
        .wsel  (req_wsel)
    );

    dmc_line_store #(
        .INDEX_W(INDEX_W), .TAG_W(TAG_W), .BLOCK_W(BLOCK_W)
    ) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_index (req_index),
        .rd_valid (line_valid),
        .rd_dirty (line_dirty),
        .rd_tag   (line_tag),
        .rd_data  (line_data),
        .wr_en    (lw_en),
        .wr_index (req_index),
        .wr_valid (lw_valid),
        .wr_dirty (lw_dirty),
        .wr_tag   (lw_tag),
        .wr_data  (lw_data)
    );

    dmc_word_lane #(
        .BLOCK_W(BLOCK_W), .WORD_W(WORD_W), .WSEL_W(WSEL_W)
    ) u_lane (
        .block  (line_data),
        .wsel   (req_wsel),
        .wdata  (ctrl_q.wdata),
        .rword  (sel_word),
        .merged (merged_block)
    );

    assign hit = line_valid && (line_tag == req_tag);

    always_comb begin
        ctrl_d     = ctrl_q;
        lw_en      = 1'b0;
        lw_valid   = line_valid;
        lw_dirty   = line_dirty;
        lw_tag     = line_tag;
        lw_data    = line_data;
        mem_req    = 1'b0;
        mem_we     = 1'b0;
        mem_addr   = {req_tag, req_index, {OFFSET_W{1'b0}}};
        mem_wblock = line_data;

        case (ctrl_q.state)
            ST_IDLE: begin
                if (cpu_valid) begin
                    ctrl_d.state = ST_COMPARE;
                    ctrl_d.we    = cpu_we;
                    ctrl_d.addr  = cpu_addr;
                    ctrl_d.wdata = cpu_wdata;
                end
            end
            ST_COMPARE: begin
                if (hit) begin
                    if (ctrl_q.we) begin
                        lw_en    = 1'b1;
                        lw_data  = merged_block;
                        lw_dirty = 1'b1;
                    end else begin
                        ctrl_d.rdata = sel_word;
                    end
                    ctrl_d.state = ST_RESPOND;
                end else if (line_valid && line_dirty) begin
                    ctrl_d.state = ST_WRITEBACK;
                end else begin
                    ctrl_d.state = ST_REFILL;
                end
            end
            ST_WRITEBACK: begin
                mem_req  = 1'b1;
                mem_we   = 1'b1;
                mem_addr = {line_tag, req_index, {OFFSET_W{1'b0}}};
                if (mem_ack) begin
                    ctrl_d.state = ST_REFILL;
                end
            end
            ST_REFILL: begin
                mem_req = 1'b1;
                if (mem_ack) begin
                    lw_en        = 1'b1;
                    lw_valid     = 1'b1;
                    lw_dirty     = 1'b0;
                    lw_tag       = req_tag;
                    lw_data      = mem_rblock;
                    ctrl_d.state = ST_COMPARE;
                end
            end
            ST_RESPOND: begin
                ctrl_d.state = ST_IDLE;
            end
            default: begin
                ctrl_d.state = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    assign cpu_ready      = (ctrl_q.state == ST_IDLE);
    assign cpu_resp_valid = (ctrl_q.state == ST_RESPOND);
    assign cpu_rdata      = ctrl_q.rdata;
endmodule

// File: rtl/dmc_checker.sv
module dmc_checker #(
    parameter int ADDR_W   = 32,
    parameter int OFFSET_W = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cpu_valid,
    input logic              cpu_ready,
    input logic              cpu_resp_valid,
    input logic              mem_req,
    input logic              mem_we,
    input logic              mem_ack,
    input logic [ADDR_W-1:0] mem_addr
);
    // R10
    stall_during_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !cpu_ready);

    // R10
    drop_ready_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_valid && cpu_ready |=> !cpu_ready);

    // R11
    hold_mem_request_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we));

    // R8
    aligned_block_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_addr[OFFSET_W-1:0] == '0));

    // R6
    refill_follows_writeback_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_we && mem_ack |=> mem_req && !mem_we);

    // R3
    single_pulse_response_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_resp_valid |=> !cpu_resp_valid && cpu_ready);
endmodule

bind dm_wb_cache dmc_checker #(
    .ADDR_W(ADDR_W), .OFFSET_W(OFFSET_W)
) u_dmc_checker (
    .clk            (clk),
    .rst_n          (rst_n),
    .cpu_valid      (cpu_valid),
    .cpu_ready      (cpu_ready),
    .cpu_resp_valid (cpu_resp_valid),
    .mem_req        (mem_req),
    .mem_we         (mem_we),
    .mem_ack        (mem_ack),
    .mem_addr       (mem_addr)
);

// File: tb/test_dm_wb_cache.sv
`timescale 1ns/1ps
module test_dm_wb_cache;
    localparam int AW  = 32;
    localparam int IW  = 4;
    localparam int OW  = 5;
    localparam int WW  = 32;
    localparam int BW  = 8 << OW;
    localparam int LAT = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cpu_valid = 1'b0;
    logic          cpu_ready;
    logic          cpu_we = 1'b0;
    logic [AW-1:0] cpu_addr = '0;
    logic [WW-1:0] cpu_wdata = '0;
    logic          cpu_resp_valid;
    logic [WW-1:0] cpu_rdata;
    logic          mem_req;
    logic          mem_we;
    logic [AW-1:0] mem_addr;
    logic [BW-1:0] mem_wblock;
    logic          mem_ack = 1'b0;
    logic [BW-1:0] mem_rblock = '0;

    int n_checks = 0;
    int n_errors = 0;

    // memory model bookkeeping
    logic [BW-1:0] wb_store [logic [AW-1:0]];
    int            n_rd = 0, n_wr = 0, ev_seq = 0, rd_seq = 0, wb_seq = 0;
    logic [AW-1:0] last_rd_addr = '0, last_wb_addr = '0;
    logic [BW-1:0] last_wb_block = '0;

    always #4 clk = ~clk;  // 125 MHz

    dm_wb_cache #(.ADDR_W(AW), .INDEX_W(IW), .OFFSET_W(OW), .WORD_W(WW)) i_dm_wb_cache (
        .clk(clk), .rst_n(rst_n),
        .cpu_valid(cpu_valid), .cpu_ready(cpu_ready), .cpu_we(cpu_we),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_resp_valid(cpu_resp_valid), .cpu_rdata(cpu_rdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wblock(mem_wblock), .mem_ack(mem_ack), .mem_rblock(mem_rblock)
    );

    function automatic logic [BW-1:0] pat_block(input logic [AW-1:0] ba);
        logic [BW-1:0] b;
        for (int k = 0; k < BW/WW; k++) b[k*WW +: WW] = ba ^ (32'h9E37_0001 * (k + 1));
        return b;
    endfunction

    function automatic logic [WW-1:0] pat_word(input logic [AW-1:0] a);
        logic [BW-1:0] b;
        b = pat_block({a[AW-1:OW], {OW{1'b0}}});
        return b[a[OW-1:2]*WW +: WW];
    endfunction

    // block memory responder
    initial begin
        forever begin
            @(negedge clk);
            if (mem_req) begin
                repeat (LAT) @(negedge clk);
                ev_seq++;
                if (mem_we) begin
                    wb_store[mem_addr] = mem_wblock;
                    n_wr++; wb_seq = ev_seq;
                    last_wb_addr = mem_addr; last_wb_block = mem_wblock;
                end else begin
                    mem_rblock = wb_store.exists(mem_addr) ? wb_store[mem_addr] : pat_block(mem_addr);
                    n_rd++; rd_seq = ev_seq; last_rd_addr = mem_addr;
                end
                mem_ack = 1'b1;
                @(negedge clk);
                mem_ack = 1'b0;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic access(input logic we, input logic [AW-1:0] a, input logic [WW-1:0] wd,
                          output logic [WW-1:0] rd, output int lat, output bit stalled);
        @(negedge clk);
        cpu_valid = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = wd;
        @(negedge clk);
        cpu_valid = 1'b0;
        stalled = !cpu_ready;
        lat = 1;
        while (!cpu_resp_valid) begin
            @(negedge clk);
            lat++;
        end
        rd = cpu_rdata;
    endtask

    task automatic t_reset();
        chk(cpu_ready == 1'b1, "R2", "ready after reset", 32'(cpu_ready), 32'd1);
        chk(mem_req == 1'b0, "R2", "no mem request after reset", 32'(mem_req), 32'd0);
        chk(cpu_resp_valid == 1'b0, "R2", "no response after reset", 32'(cpu_resp_valid), 32'd0);
    endtask

    task automatic t_cold_read();
        logic [WW-1:0] rd; int lat; bit st; int r0, w0;
        r0 = n_rd; w0 = n_wr;
        access(1'b0, 32'h0000_1044, '0, rd, lat, st);
        chk(n_rd == r0 + 1, "R2", "cold miss reads memory", 32'(n_rd - r0), 32'd1);
        chk(n_wr == w0, "R7", "no write-back on invalid line", 32'(n_wr - w0), 32'd0);
        chk(last_rd_addr == 32'h0000_1040, "R8", "aligned refill address", last_rd_addr, 32'h1040);
        chk(rd == pat_word(32'h1044), "R4", "cold miss word 1", rd, pat_word(32'h1044));
    endtask

    task automatic t_read_hit();
        logic [WW-1:0] rd; int lat; bit st; int r0;
        r0 = n_rd;
        access(1'b0, 32'h0000_104C, '0, rd, lat, st);
        chk(lat == 2, "R3", "hit latency", 32'(lat), 32'd2);
        chk(n_rd == r0, "R3", "hit makes no memory read", 32'(n_rd - r0), 32'd0);
        chk(rd == pat_word(32'h104C), "R4", "hit word 3", rd, pat_word(32'h104C));
        chk(st, "R10", "ready low after accept", 32'(st), 32'd1);
    endtask

    task automatic t_write_hit();
        logic [WW-1:0] rd; int lat; bit st; int r0, w0;
        r0 = n_rd; w0 = n_wr;
        access(1'b1, 32'h0000_1048, 32'hDEAD_BEEF, rd, lat, st);
        chk((n_rd == r0) && (n_wr == w0), "R5", "write hit no memory traffic",
            32'(n_rd - r0 + n_wr - w0), 32'd0);
        access(1'b0, 32'h0000_1048, '0, rd, lat, st);
        chk(rd == 32'hDEAD_BEEF, "R5", "read back written word", rd, 32'hDEAD_BEEF);
        access(1'b0, 32'h0000_1044, '0, rd, lat, st);
        chk(rd == pat_word(32'h1044), "R5", "neighbour word untouched", rd, pat_word(32'h1044));
    endtask

    task automatic t_dirty_evict();
        logic [WW-1:0] rd; int lat; bit st; int r0, w0;
        r0 = n_rd; w0 = n_wr;
        access(1'b0, 32'h0000_1240, '0, rd, lat, st);  // same index 2, other tag (R1)
        chk(n_wr == w0 + 1, "R6", "dirty victim written back", 32'(n_wr - w0), 32'd1);
        chk(last_wb_addr == 32'h0000_1040, "R6", "write-back address", last_wb_addr, 32'h1040);
        chk(last_wb_block[2*WW +: WW] == 32'hDEAD_BEEF, "R6", "write-back word 2",
            last_wb_block[2*WW +: WW], 32'hDEAD_BEEF);
        chk(last_wb_block[1*WW +: WW] == pat_word(32'h1044), "R6", "write-back word 1",
            last_wb_block[1*WW +: WW], pat_word(32'h1044));
        chk(n_rd == r0 + 1 && rd_seq > wb_seq, "R6", "refill after write-back",
            32'(rd_seq), 32'(wb_seq + 1));
        chk(rd == pat_word(32'h1240), "R1", "conflicting block data", rd, pat_word(32'h1240));
    endtask

    task automatic t_clean_evict();
        logic [WW-1:0] rd; int lat; bit st; int r0, w0;
        r0 = n_rd; w0 = n_wr;
        access(1'b0, 32'h0000_1048, '0, rd, lat, st);
        chk(n_wr == w0, "R7", "clean victim not written", 32'(n_wr - w0), 32'd0);
        chk(n_rd == r0 + 1, "R7", "clean miss reads once", 32'(n_rd - r0), 32'd1);
        chk(rd == 32'hDEAD_BEEF, "R6", "written-back data survives", rd, 32'hDEAD_BEEF);
    endtask

    task automatic t_write_miss();
        logic [WW-1:0] rd; int lat; bit st; int r0, w0;
        r0 = n_rd; w0 = n_wr;
        access(1'b1, 32'h0000_3004, 32'h1234_5678, rd, lat, st);
        chk(n_rd == r0 + 1 && n_wr == w0, "R9", "write miss allocates by refill",
            32'(n_rd - r0), 32'd1);
        access(1'b0, 32'h0000_3004, '0, rd, lat, st);
        chk(rd == 32'h1234_5678 && lat == 2, "R9", "merged word hits", rd, 32'h1234_5678);
        access(1'b0, 32'h0000_3008, '0, rd, lat, st);
        chk(rd == pat_word(32'h3008), "R9", "rest of block refilled", rd, pat_word(32'h3008));
        access(1'b0, 32'h0000_3204, '0, rd, lat, st);
        chk(n_wr == w0 + 1 && last_wb_addr == 32'h0000_3000, "R9", "allocated line dirty",
            last_wb_addr, 32'h3000);
        chk(last_wb_block[1*WW +: WW] == 32'h1234_5678, "R9", "merged word written back",
            last_wb_block[1*WW +: WW], 32'h1234_5678);
    endtask

    task automatic t_index_sweep();
        logic [WW-1:0] rd; int lat; bit st; int r0, w0;
        r0 = n_rd; w0 = n_wr;
        for (int i = 0; i < (1 << IW); i++) begin
            access(1'b0, 32'h0000_8000 + 32'(i * 32) + 32'(4 * (i % 8)), '0, rd, lat, st);
        end
        chk(n_rd == r0 + (1 << IW), "R1", "one refill per line", 32'(n_rd - r0), 32'(1 << IW));
        chk(n_wr == w0, "R7", "clean lines not written", 32'(n_wr - w0), 32'd0);
        for (int i = 0; i < (1 << IW); i++) begin
            logic [AW-1:0] a;
            a = 32'h0000_8000 + 32'(i * 32) + 32'(4 * (i % 8));
            access(1'b0, a, '0, rd, lat, st);
            chk(lat == 2 && rd == pat_word(a), "R8", "sweep line hits", rd, pat_word(a));
        end
        chk(n_rd == r0 + (1 << IW), "R1", "no refill on second pass", 32'(n_rd - r0), 32'(1 << IW));
    endtask

    task automatic finish_run();
        $display("  Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_cold_read();
        t_read_hit();
        t_write_hit();
        t_dirty_evict();
        t_clean_evict();
        t_write_miss();
        t_index_sweep();
        repeat (2) @(negedge clk);
        finish_run();
    end
endmodule